// File: doc/BRIEF.md
# Byte-Wide Multiplexed Bus Interface Unit

This block sits between a 16-bit internal data path and a narrow external bus. On that bus the low eight lines carry the address in one phase and the data in a later phase. The upper address lines carry only the address. A request is a single start pulse with an address, a byte/word flag, a read/write select and write data. The unit turns each request into one external byte cycle for a byte access, or two for a word access. It splits write words into bytes and builds read bytes back into a word. When the last byte cycle has ended, it returns a one-cycle done pulse together with the read data.

Each byte cycle lasts four clock cycles, called T1 to T4. In T1 the address is driven and an address latch enable strobe is pulsed. In T2 and T3 the read or write strobe and the data enable are active. In T4 the bus goes quiet. A direction signal tells an external transceiver which way data flows. Words use little-endian byte order: the low byte is at the given address and the high byte is at the next address. A word may start at any address, even or odd, and the second address wraps at the top of the address space.

Top module: `byte_bus_unit`

## Requirements
- R1: After reset, the ale, den, dtr, rdStb, wrStb, adOe and reqDone outputs are all low.
- R2: A byte request sampled at a clock edge produces one four-cycle byte cycle (T1 to T4). reqDone is high in the single cycle that follows T4, which is the fifth cycle after the start edge.
- R3: ale is high for exactly one cycle, in T1. In that cycle adOe is high, adOut carries address bits 7:0, addrHi carries the upper address bits, and den is low.
- R4: rdStb (read) or wrStb (write) is high in T2 and T3 of every byte cycle and in no other cycle. The two strobes are never high together.
- R5: dtr is 1 for a write and 0 for a read. It is set from T1 onward, so it is stable when den rises. den is high only in T2 and T3. For a read, adOe is low whenever den is high.
- R6: In T2 and T3 of a write, adOut carries wdata[7:0] for the first byte cycle and wdata[15:8] for the second.
- R7: The second byte cycle of a word uses the address plus one, modulo 2^20. An odd start address is accepted like an even one.
- R8: Read data is sampled from adIn at the end of T3. The byte from the first cycle goes to reqRdata[7:0] and the byte from the second cycle goes to reqRdata[15:8]. For a byte read, reqRdata[15:8] is zero.
- R9: reqDone is a one-cycle pulse that comes only after the last byte cycle, and reqRdata is valid while it is high. A word request gives its done pulse in the ninth cycle after the start edge.
- R10: A word request produces exactly two ale pulses and a byte request produces exactly one. A start pulse, or a change on any request input, while a transaction is in progress has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start pulse, accepted when idle |
| reqAddr | input | 20 | Byte address of the access |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write data, low byte first |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 16 | Assembled read data |
| adOut | output | 8 | Shared address/data lines, driven value |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | 8 | Shared address/data lines, received value |
| addrHi | output | 12 | Address-only lines (address bits 19:8) |
| ale | output | 1 | Address latch enable |
| den | output | 1 | Data transceiver enable |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| rdStb | output | 1 | Read strobe |
| wrStb | output | 1 | Write strobe |

## Verification
The bench builds the unit with its default parameters: a 20-bit address and 8-bit bus lanes. With these values the top address 20'hFFFFF is in reach, so a word access there exercises the wrap of its second byte to address zero. A bench-side byte memory, addressed by the latched ale address, supplies the read data, so byte order and the second address can be checked together. A stray start pulse in the middle of a transaction, together with changed request inputs, shows that the accepted request is held.

// File: rtl/byte_bus_pkg.sv
package byte_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic addrPhase;  // T1: drive the address on the shared lines
    logic second;     // second byte cycle of a word
    logic capLo;      // sample the bus into the low lane
    logic capHi;      // sample the bus into the high lane
  } dpCtl_t;
endpackage

// File: rtl/bbu_ctrl.sv
module bbu_ctrl
  import byte_bus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqStart,
  input  logic   reqWord,
  input  logic   reqWrite,
  output dpCtl_t ctl,
  output logic   ale,
  output logic   den,
  output logic   dtr,
  output logic   rdStb,
  output logic   wrStb,
  output logic   adOe,
  output logic   reqDone
);
  busState_e state;
  logic      secondByte;
  logic      isWord;
  logic      isWrite;
  logic      doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      secondByte <= 1'b0;
      isWord     <= 1'b0;
      isWrite    <= 1'b0;
      doneReg    <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqStart) begin
            state      <= ST_T1;
            secondByte <= 1'b0;
            isWord     <= reqWord;
            isWrite    <= reqWrite;
          end
        end
        ST_T1: state <= ST_T2;
        ST_T2: state <= ST_T3;
        ST_T3: state <= ST_T4;
        ST_T4: begin
          if (isWord && !secondByte) begin
            secondByte <= 1'b1;
            state      <= ST_T1;
          end else begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic midPhase;
  assign midPhase = (state == ST_T2) || (state == ST_T3);

  assign ale     = (state == ST_T1);
  assign den     = midPhase;
  assign dtr     = (state != ST_IDLE) && isWrite;
  assign rdStb   = midPhase && !isWrite;
  assign wrStb   = midPhase && isWrite;
  assign adOe    = (state == ST_T1) || (midPhase && isWrite);
  assign reqDone = doneReg;

  always_comb begin
    ctl.load      = (state == ST_IDLE) && reqStart;
    ctl.addrPhase = (state == ST_T1);
    ctl.second    = secondByte;
    ctl.capLo     = (state == ST_T3) && !isWrite && !secondByte;
    ctl.capHi     = (state == ST_T3) && !isWrite && secondByte;
  end
endmodule

// File: rtl/bbu_datapath.sv
module bbu_datapath
  import byte_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [2*BYTE_W-1:0]  reqWdata,
  input  logic [BYTE_W-1:0]    adIn,
  output logic [BYTE_W-1:0]    adOut,
  output logic [ADDR_W-BYTE_W-1:0] addrHi,
  output logic [2*BYTE_W-1:0]  reqRdata
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int LANES  = 2;

  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] wdataReg;
  logic [WORD_W-1:0] rdataReg;
  logic [ADDR_W-1:0] curAddr;
  logic [BYTE_W-1:0] wrByte;
  logic [LANES-1:0]  capLane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (ctl.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  // second byte address wraps naturally at the address width
  assign curAddr = ctl.second ? addrReg + ADDR_W'(1) : addrReg;
  assign wrByte  = ctl.second ? wdataReg[BYTE_W +: BYTE_W] : wdataReg[0 +: BYTE_W];
  assign adOut   = ctl.addrPhase ? curAddr[BYTE_W-1:0] : wrByte;
  assign addrHi  = curAddr[ADDR_W-1:BYTE_W];
  assign capLane = {ctl.capHi, ctl.capLo};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || ctl.load) rdataReg[lane*BYTE_W +: BYTE_W] <= '0;
      else if (capLane[lane]) rdataReg[lane*BYTE_W +: BYTE_W] <= adIn;
    end
  end

  assign reqRdata = rdataReg;
endmodule

// File: rtl/byte_bus_unit.sv
module byte_bus_unit
  import byte_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqStart,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWord,
  input  logic                     reqWrite,
  input  logic [2*BYTE_W-1:0]      reqWdata,
  output logic                     reqDone,
  output logic [2*BYTE_W-1:0]      reqRdata,
  output logic [BYTE_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [BYTE_W-1:0]        adIn,
  output logic [ADDR_W-BYTE_W-1:0] addrHi,
  output logic                     ale,
  output logic                     den,
  output logic                     dtr,
  output logic                     rdStb,
  output logic                     wrStb
);
  dpCtl_t ctl;

  bbu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWord(reqWord),
    .reqWrite(reqWrite), .ctl(ctl), .ale(ale), .den(den), .dtr(dtr),
    .rdStb(rdStb), .wrStb(wrStb), .adOe(adOe), .reqDone(reqDone)
  );

  bbu_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .adIn(adIn), .adOut(adOut), .addrHi(addrHi),
    .reqRdata(reqRdata)
  );
endmodule

// File: rtl/bbu_checker.sv
module bbu_checker (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic den,
  input logic dtr,
  input logic rdStb,
  input logic wrStb,
  input logic adOe,
  input logic reqDone
);
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));
  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  a_r3_ale_drives: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (adOe && !den));
  a_r4_ale_then_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (rdStb || wrStb));
  a_r4_rd_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStb) |=> rdStb);
  a_r4_wr_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStb) |=> wrStb);
  a_r5_dir_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(den) |-> $stable(dtr));
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    (den && !dtr) |-> !adOe);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (!den && !ale));
endmodule

bind byte_bus_unit bbu_checker chk_i (
  .clk(clk), .rstN(rstN), .ale(ale), .den(den), .dtr(dtr),
  .rdStb(rdStb), .wrStb(wrStb), .adOe(adOe), .reqDone(reqDone)
);

// File: tb/byte_bus_unit_tb_top.sv
`timescale 1ns/1ps
module byte_bus_unit_tb_top;
  localparam int AW = 20;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqWord = 1'b0;
  logic reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic reqDone;
  logic [15:0] reqRdata;
  logic [BW-1:0] adOut;
  logic adOe;
  logic [BW-1:0] adIn;
  logic [AW-BW-1:0] addrHi;
  logic ale, den, dtr, rdStb, wrStb;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  byte_bus_unit dut_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .reqWord(reqWord), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqDone(reqDone), .reqRdata(reqRdata), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .addrHi(addrHi), .ale(ale), .den(den), .dtr(dtr),
    .rdStb(rdStb), .wrStb(wrStb)
  );

  // memory model: byte content derived from its address
  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
  endfunction

  logic [AW-1:0] latchAddr = '0;
  assign adIn = memByte(latchAddr);

  int aleCnt, rdCnt, wrCnt, dirErr;
  logic [AW-1:0] aleAddr [2];
  logic [7:0] wrB [2];
  logic curWrite;

  always @(negedge clk) begin
    if (ale) begin
      latchAddr = {addrHi, adOut};
      if (aleCnt < 2) aleAddr[aleCnt] = {addrHi, adOut};
      aleCnt++;
    end
    if (rdStb) rdCnt++;
    if (wrStb) begin
      wrCnt++;
      if (aleCnt >= 1 && aleCnt <= 2) wrB[aleCnt-1] = adOut;
    end
    if (den && (dtr !== curWrite)) dirErr++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic [AW-1:0] a, input bit w, input bit wr,
                        input logic [15:0] wd, input int injectAt);
    int cyc;
    logic [AW-1:0] a2;
    logic [15:0] expR;
    @(negedge clk);
    aleCnt = 0; rdCnt = 0; wrCnt = 0; dirErr = 0;
    wrB[0] = '0; wrB[1] = '0; curWrite = wr;
    reqStart = 1'b1; reqAddr = a; reqWord = w; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqStart = 1'b0;
    cyc = 1;
    while (!reqDone && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (cyc == injectAt) begin
        reqStart = 1'b1; reqAddr = a ^ 20'h5555A; reqWord = !w;
        reqWrite = !wr; reqWdata = ~wd;
      end else begin
        reqStart = 1'b0;
      end
    end
    a2 = a + 20'd1;
    expR = w ? {memByte(a2), memByte(a)} : {8'h00, memByte(a)};
    check(cyc == (w ? 9 : 5), w ? "R9 done cycle" : "R2 done cycle", cyc, w ? 9 : 5);
    check(aleCnt == (w ? 2 : 1), "R10 ale count", aleCnt, w ? 2 : 1);
    check(aleAddr[0] == a, "R3 first address", aleAddr[0], a);
    if (w) check(aleAddr[1] == a2, "R7 second address", aleAddr[1], a2);
    check((wr ? wrCnt : rdCnt) == (w ? 4 : 2) && (wr ? rdCnt : wrCnt) == 0,
          "R4 strobe cycles", wr ? wrCnt : rdCnt, w ? 4 : 2);
    check(dirErr == 0, "R5 direction", dirErr, 0);
    if (wr) begin
      check(wrB[0] == wd[7:0], "R6 low byte", wrB[0], wd[7:0]);
      if (w) check(wrB[1] == wd[15:8], "R6 high byte", wrB[1], wd[15:8]);
    end else begin
      check(reqRdata == expR, "R8 read data", reqRdata, expR);
    end
    @(negedge clk);
    check(!reqDone, "R9 done single pulse", reqDone, 0);
  endtask

  // addr, word, write, wdata
  localparam logic [37:0] VEC [6] = '{
    {20'h01234, 1'b0, 1'b0, 16'h0000},
    {20'h01235, 1'b1, 1'b0, 16'h0000},
    {20'h02000, 1'b1, 1'b1, 16'hBEEF},
    {20'h0ABCD, 1'b0, 1'b1, 16'h12A5},
    {20'hFFFFF, 1'b1, 1'b0, 16'h0000},
    {20'hFFFFF, 1'b1, 1'b1, 16'hC37E}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({ale, den, dtr, rdStb, wrStb, adOe, reqDone} == 7'b0,
          "R1 reset outputs", {ale, den, dtr, rdStb, wrStb, adOe, reqDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({ale, den, rdStb, wrStb, reqDone} == 5'b0, "R1 idle after reset",
          {ale, den, rdStb, wrStb, reqDone}, 0);

    for (int i = 0; i < 6; i++)
      runTxn(VEC[i][37:18], VEC[i][17], VEC[i][16], VEC[i][15:0], 0);

    // R10: stray start and changed inputs while busy are ignored
    runTxn(20'h00777, 1'b0, 1'b0, 16'h0000, 3);
    runTxn(20'h13579, 1'b1, 1'b1, 16'h9A3C, 6);
    // odd address word read straight after a write
    runTxn(20'h7FFFF, 1'b1, 1'b0, 16'h0000, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule